// File: doc/BRIEF.md
# Dual-Rail Carry-Select Adder/Counter

This block is an N-bit arithmetic datapath made of one slice per bit. Each slice works out its sum bit and its carry-out for both possible incoming carries at the same time. Two carry rails run up the word: one assumes that the chain-level carry is 0, the other assumes it is 1. At the end a single select line, the real carry into the chain, picks which rail supplies every sum bit and the final carry. The chain-level carry is not a ripple signal, so it never has to travel along the word.

The same datapath serves two uses. It can add or subtract two operands, with the operation chosen at run time. It can also count up or down by one on its own result register. A holding register sits behind the combinational result. That register has a clock enable, a synchronous clear, a synchronous load, a synchronous reset and an asynchronous clear. The designer can place the start of the chain at any bit. Bits below that start pass operand A straight through, and the external carry enters at the start bit.

Top module: `csel_counter`

## Requirements
- R1: With `cnt_en`=0 and `add_sub`=1, `{cout, sum_comb}` equals `opa + opb + cin` as a WIDTH+1-bit value.
- R2: With `cnt_en`=0 and `add_sub`=0, `sum_comb` equals `opa - opb - cin` modulo 2^WIDTH, where `cin` acts as a borrow-in. `cout` is 1 exactly when no borrow occurs, that is when `opa >= opb + cin`.
- R3: With `cnt_en`=1 and `up_dn`=1, `sum_comb` equals `sum_q + 1` modulo 2^WIDTH. `cout` is 1 only when `sum_q` is all ones. `opa`, `opb`, `cin` and `add_sub` have no effect on the result.
- R4: With `cnt_en`=1 and `up_dn`=0, `sum_comb` equals `sum_q - 1` modulo 2^WIDTH. `cout` is 0 only when `sum_q` is zero.
- R5: On a rising edge with `clk_en`=1, `sclr`=0 and `sload`=0, `sum_q` takes the value that `sum_comb` held before the edge.
- R6: On a rising edge with `clk_en`=1 and `sclr`=1, `sum_q` becomes zero, whatever the state of `sload`.
- R7: On a rising edge with `clk_en`=1, `sclr`=0 and `sload`=1, `sum_q` takes `load_data`.
- R8: On a rising edge with `clk_en`=0, `sum_q` keeps its value, whatever the states of `sclr`, `sload` and `cnt_en`.
- R9: `aclr`=1 clears `sum_q` at once, with no clock edge needed. `rst`=1 clears it at the next rising edge.
- R10: When START_BIT = S > 0, bits below S of `sum_comb` equal those bits of `opa`. Bits S and up hold the R1/R2 result of the upper fields, with `cin` entering at bit S and `cout` taken from the top bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| aclr | input | 1 | Asynchronous clear of the result register, active high |
| opa | input | WIDTH | Operand A |
| opb | input | WIDTH | Operand B |
| cin | input | 1 | Chain carry-in for add, borrow-in for subtract |
| add_sub | input | 1 | 1 = add, 0 = subtract |
| clk_en | input | 1 | Enables every synchronous register action |
| cnt_en | input | 1 | 1 = count on `sum_q`, 0 = operate on the operands |
| up_dn | input | 1 | Count direction, 1 = up |
| sclr | input | 1 | Synchronous clear of the whole word |
| sload | input | 1 | Synchronous load of the whole word |
| load_data | input | WIDTH | Value taken on a load |
| sum_comb | output | WIDTH | Unregistered result |
| sum_q | output | WIDTH | Registered result |
| cout | output | 1 | Final carry, the no-borrow flag when subtracting |

## Verification
The operand path is exercised with a fixed table of additions and subtractions. The table pairs each operand pair with both carry-in values, so a rail swap or an inverted select shows up as an off-by-one. It also covers all-ones plus one and zero minus zero with borrow, which separate a correct top-rail carry from a carry read off the wrong rail. Random operand pairs are then compared against a reference built from plain integer sums and comparisons. Counting runs up through the all-ones wrap and down through the zero wrap while the operand inputs hold unrelated values, which confirms that the counter ignores them. A second instance, with the chain starting at bit 4, shows that the low field passes through and that the carry enters at the offset.

// File: rtl/csel_pkg.sv
package csel_pkg;
  typedef enum logic {OP_SUB = 1'b0, OP_ADD = 1'b1} op_e;

  // carry pair: rail0 assumes chain carry 0, rail1 assumes chain carry 1
  typedef struct packed {
    logic r1;
    logic r0;
  } rail_t;
endpackage

// File: rtl/csel_slice.sv
module csel_slice
  import csel_pkg::*;
(
  input  logic  a,
  input  logic  b,
  input  rail_t cin_r,
  output rail_t cout_r,
  output logic  s0,
  output logic  s1
);
  logic p;
  assign p = a ^ b;

  // both candidate sums and carries, one per rail
  assign s0        = p ^ cin_r.r0;
  assign s1        = p ^ cin_r.r1;
  assign cout_r.r0 = (a & b) | (p & cin_r.r0);
  assign cout_r.r1 = (a & b) | (p & cin_r.r1);
endmodule

// File: rtl/csel_chain.sv
module csel_chain
  import csel_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int START_BIT = 0
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sel,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int SPAN = WIDTH - START_BIT;

  rail_t rail [SPAN+1];
  logic [WIDTH-1:0] s0, s1;

  assign rail[0] = '{r1: 1'b1, r0: 1'b0};

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i < START_BIT) begin : g_pass
      assign s0[i] = a[i];
      assign s1[i] = a[i];
    end else begin : g_slice
      csel_slice u_slice (
        .a      (a[i]),
        .b      (b[i]),
        .cin_r  (rail[i-START_BIT]),
        .cout_r (rail[i-START_BIT+1]),
        .s0     (s0[i]),
        .s1     (s1[i])
      );
    end
  end

  // the real chain carry picks one rail for the whole word
  assign sum  = sel ? s1 : s0;
  assign cout = sel ? rail[SPAN].r1 : rail[SPAN].r0;
endmodule

// File: rtl/csel_operand.sv
module csel_operand
  import csel_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [WIDTH-1:0] acc,
  input  logic             cin,
  input  logic             add_sub,
  input  logic             cnt_en,
  input  logic             up_dn,
  output logic [WIDTH-1:0] a_eff,
  output logic [WIDTH-1:0] b_eff,
  output logic             sel
);
  op_e              op;
  logic [WIDTH-1:0] b_raw;
  logic             c_raw;

  always_comb begin
    op    = op_e'(cnt_en ? up_dn : add_sub);
    a_eff = cnt_en ? acc : opa;
    b_raw = cnt_en ? '0 : opb;
    c_raw = cnt_en ? 1'b1 : cin;
    // operation enters as inversion of B and of the chain carry
    b_eff = (op == OP_ADD) ? b_raw : ~b_raw;
    sel   = (op == OP_ADD) ? c_raw : ~c_raw;
  end
endmodule

// File: rtl/csel_acc_reg.sv
module csel_acc_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             aclr,
  input  logic             clk_en,
  input  logic             sclr,
  input  logic             sload,
  input  logic [WIDTH-1:0] load_data,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or posedge aclr) begin
    if (aclr)          q <= '0;
    else if (rst)      q <= '0;
    else if (clk_en) begin
      if (sclr)        q <= '0;
      else if (sload)  q <= load_data;
      else             q <= d;
    end
  end
endmodule

// File: rtl/csel_counter.sv
module csel_counter #(
  parameter int WIDTH     = 8,
  parameter int START_BIT = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             aclr,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             cin,
  input  logic             add_sub,
  input  logic             clk_en,
  input  logic             cnt_en,
  input  logic             up_dn,
  input  logic             sclr,
  input  logic             sload,
  input  logic [WIDTH-1:0] load_data,
  output logic [WIDTH-1:0] sum_comb,
  output logic [WIDTH-1:0] sum_q,
  output logic             cout
);
  logic [WIDTH-1:0] a_eff, b_eff;
  logic             sel;

  csel_operand #(.WIDTH(WIDTH)) u_opnd (
    .opa(opa), .opb(opb), .acc(sum_q), .cin(cin), .add_sub(add_sub),
    .cnt_en(cnt_en), .up_dn(up_dn), .a_eff(a_eff), .b_eff(b_eff), .sel(sel)
  );

  csel_chain #(.WIDTH(WIDTH), .START_BIT(START_BIT)) u_chain (
    .a(a_eff), .b(b_eff), .sel(sel), .sum(sum_comb), .cout(cout)
  );

  csel_acc_reg #(.WIDTH(WIDTH)) u_reg (
    .clk(clk), .rst(rst), .aclr(aclr), .clk_en(clk_en), .sclr(sclr),
    .sload(sload), .load_data(load_data), .d(sum_comb), .q(sum_q)
  );
endmodule

// File: rtl/csel_counter_chk.sv
module csel_counter_chk #(
  parameter int WIDTH     = 8,
  parameter int START_BIT = 0
) (
  input logic             clk,
  input logic             rst,
  input logic             aclr,
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic             cin,
  input logic             add_sub,
  input logic             clk_en,
  input logic             cnt_en,
  input logic             up_dn,
  input logic             sclr,
  input logic             sload,
  input logic [WIDTH-1:0] load_data,
  input logic [WIDTH-1:0] sum_comb,
  input logic [WIDTH-1:0] sum_q,
  input logic             cout
);
  // R6
  sclr_zero_chk: assert property (@(posedge clk) disable iff (rst || aclr)
    (clk_en && sclr) |=> (sum_q == '0));

  // R7
  sload_take_chk: assert property (@(posedge clk) disable iff (rst || aclr)
    (clk_en && !sclr && sload) |=> (sum_q == $past(load_data)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst || aclr)
    !clk_en |=> $stable(sum_q));

  // R5
  update_chk: assert property (@(posedge clk) disable iff (rst || aclr)
    (clk_en && !sclr && !sload) |=> (sum_q == $past(sum_comb)));

  // R9
  aclr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    aclr |-> (sum_q == '0));

  if (START_BIT == 0) begin : g_full
    // R3
    count_up_chk: assert property (@(posedge clk) disable iff (rst || aclr)
      (cnt_en && up_dn) |-> (sum_comb == WIDTH'(sum_q + 1'b1)));
    // R4
    count_dn_chk: assert property (@(posedge clk) disable iff (rst || aclr)
      (cnt_en && !up_dn) |-> (cout == (sum_q != '0)));
    // R2
    sub_chk: assert property (@(posedge clk) disable iff (rst || aclr)
      (!cnt_en && !add_sub && !cin) |-> (sum_comb == WIDTH'(opa - opb)));
  end
endmodule

bind csel_counter csel_counter_chk #(.WIDTH(WIDTH), .START_BIT(START_BIT)) u_chk (
  .clk(clk), .rst(rst), .aclr(aclr), .opa(opa), .opb(opb), .cin(cin),
  .add_sub(add_sub), .clk_en(clk_en), .cnt_en(cnt_en), .up_dn(up_dn),
  .sclr(sclr), .sload(sload), .load_data(load_data), .sum_comb(sum_comb),
  .sum_q(sum_q), .cout(cout)
);

// File: tb/csel_counter_bench.sv
module csel_counter_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1, aclr = 1'b0;
  logic [W-1:0] opa = '0, opb = '0, load_data = '0;
  logic cin = 1'b0, add_sub = 1'b1, clk_en = 1'b0, cnt_en = 1'b0, up_dn = 1'b1;
  logic sclr = 1'b0, sload = 1'b0;
  logic [W-1:0] sum_comb, sum_q, off_comb, off_q;
  logic cout, off_cout;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  csel_counter #(.WIDTH(W), .START_BIT(0)) u_csel_counter (
    .clk(clk), .rst(rst), .aclr(aclr), .opa(opa), .opb(opb), .cin(cin),
    .add_sub(add_sub), .clk_en(clk_en), .cnt_en(cnt_en), .up_dn(up_dn),
    .sclr(sclr), .sload(sload), .load_data(load_data),
    .sum_comb(sum_comb), .sum_q(sum_q), .cout(cout));

  csel_counter #(.WIDTH(W), .START_BIT(4)) u_csel_counter_off (
    .clk(clk), .rst(rst), .aclr(aclr), .opa(opa), .opb(opb), .cin(cin),
    .add_sub(add_sub), .clk_en(clk_en), .cnt_en(cnt_en), .up_dn(up_dn),
    .sclr(sclr), .sload(sload), .load_data(load_data),
    .sum_comb(off_comb), .sum_q(off_q), .cout(off_cout));

  // {add_sub, cin, opa, opb, exp_cout, exp_sum}
  localparam logic [26:0] VEC [12] = '{
    {1'b1, 1'b0, 8'h12, 8'h34, 1'b0, 8'h46},
    {1'b1, 1'b1, 8'hFF, 8'h01, 1'b1, 8'h01},
    {1'b1, 1'b0, 8'hFF, 8'h01, 1'b1, 8'h00},
    {1'b1, 1'b1, 8'h7F, 8'h00, 1'b0, 8'h80},
    {1'b1, 1'b0, 8'hA5, 8'h5A, 1'b0, 8'hFF},
    {1'b1, 1'b1, 8'hA5, 8'h5A, 1'b1, 8'h00},
    {1'b0, 1'b0, 8'h50, 8'h20, 1'b1, 8'h30},
    {1'b0, 1'b0, 8'h20, 8'h50, 1'b0, 8'hD0},
    {1'b0, 1'b1, 8'h50, 8'h20, 1'b1, 8'h2F},
    {1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 8'h00},
    {1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 8'hFF},
    {1'b0, 1'b0, 8'h80, 8'h01, 1'b1, 8'h7F}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W:0] ref_sum;
    logic       ref_c;
    @(negedge clk);
    tick();
    tick();
    rst = 1'b0;
    // R9 synchronous reset state
    check("R9 reset", 16'(sum_q), 16'h0);

    // R1 R2 table
    for (int i = 0; i < 12; i++) begin
      {add_sub, cin, opa, opb} = VEC[i][26:9];
      #1;
      check(VEC[i][26] ? "R1 table" : "R2 table", {7'b0, cout, sum_comb}, {7'b0, VEC[i][8:0]});
      @(negedge clk);
    end

    // R1 R2 random against integer reference
    for (int i = 0; i < 200; i++) begin
      opa = W'($urandom);
      opb = W'($urandom);
      cin = 1'($urandom);
      add_sub = 1'($urandom);
      #1;
      if (add_sub) begin
        ref_sum = {1'b0, opa} + {1'b0, opb} + {8'b0, cin};
        check("R1 random", {7'b0, cout, sum_comb}, {7'b0, ref_sum});
      end else begin
        ref_c = (int'(opa) >= int'(opb) + int'(cin));
        check("R2 random", {7'b0, cout, sum_comb}, {7'b0, ref_c, W'(opa - opb - cin)});
      end
      @(negedge clk);
    end

    // R10 offset chain: low nibble from opa, carry enters bit 4
    add_sub = 1'b1; cin = 1'b0; opa = 8'h3C; opb = 8'h25;
    #1;
    check("R10 offset add", {7'b0, off_cout, off_comb}, {7'b0, 1'b0, 8'h5C});
    cin = 1'b1; opa = 8'hF7; opb = 8'h1A;
    #1;
    check("R10 offset carry", {7'b0, off_cout, off_comb}, {7'b0, 1'b1, 8'h17});
    @(negedge clk);

    // R7 load
    clk_en = 1'b1; sload = 1'b1; load_data = 8'hFE;
    tick();
    sload = 1'b0;
    check("R7 load", 16'(sum_q), 16'hFE);

    // R3 count up with unrelated operand inputs
    cnt_en = 1'b1; up_dn = 1'b1; opa = 8'h11; opb = 8'h77; cin = 1'b0; add_sub = 1'b0;
    #1;
    check("R3 count up", {7'b0, cout, sum_comb}, {7'b0, 1'b0, 8'hFF});
    tick();
    // R5 register follows comb
    check("R5 update", 16'(sum_q), 16'hFF);
    check("R3 wrap", {7'b0, cout, sum_comb}, {7'b0, 1'b1, 8'h00});
    tick();
    check("R5 wrap update", 16'(sum_q), 16'h00);

    // R4 count down through zero
    up_dn = 1'b0;
    #1;
    check("R4 wrap", {7'b0, cout, sum_comb}, {7'b0, 1'b0, 8'hFF});
    tick();
    check("R4 count down", {7'b0, cout, sum_comb}, {7'b0, 1'b1, 8'hFE});

    // R8 clock enable low blocks everything
    clk_en = 1'b0; sclr = 1'b1; sload = 1'b1; load_data = 8'h33;
    tick();
    tick();
    check("R8 hold", 16'(sum_q), 16'hFF);

    // R6 clear wins over load
    clk_en = 1'b1;
    tick();
    check("R6 clear over load", 16'(sum_q), 16'h00);
    sclr = 1'b0;
    tick();
    check("R7 load 33", 16'(sum_q), 16'h33);
    sload = 1'b0; clk_en = 1'b0;

    // R9 asynchronous clear, before any edge
    #1;
    aclr = 1'b1;
    #1;
    check("R9 aclr", 16'(sum_q), 16'h00);
    @(negedge clk);
    aclr = 1'b0;
    tick();
    check("R9 aclr held", 16'(sum_q), 16'h00);

    finish_run();
  end
endmodule